// File: doc/BRIEF.md
# Peak-Centred Snapshot Capture Controller

The block takes a continuous stream of sample frames, each frame holding one simultaneous sample from every channel. It keeps one frame in every D, and writes each kept frame into a circular region of external event memory through a 32-bit data path. A frame wider than one word is split into consecutive words. Sample writes always have priority on the memory port. A four-entry frame queue absorbs the moment when a frame arrives while the port is busy, so no input frame is ever lost. A processor can read or write the same memory, and its requests are granted only in cycles that carry no sample write.

A trigger watches the magnitude of one selected channel. When the trigger is armed and a kept frame exceeds the threshold, capture runs on for half of the programmed event length. This leaves the triggering frame near the middle of the most recent event-length window. The block then reports the window's start address with a one-cycle done pulse and stays disarmed until software acknowledges. Separately, the block reports the largest channel magnitude seen over each fixed count of input frames, which gives a low-rate activity trace.

Top module: `snapcap`

## Requirements
- R1: Each kept frame is written as WPF = NCH*SW/32 words, lowest bits first, at consecutive word addresses that wrap modulo 2^AW, starting from address 0 after reset. Channel c occupies frame bits [c*SW +: SW]. The first word goes out in the cycle after the frame is accepted, unless earlier frames are still queued.
- R2: With decimation value D (0 and 1 both mean 1), the first valid frame after reset is kept, and after that every D-th valid frame is kept. Frames that are not kept are never written.
- R3: Sample writes take the memory port whenever a frame is queued. The queue holds four frames and never loses an accepted frame.
- R4: The trigger fires on a kept frame while armed, when the two's-complement magnitude of the selected channel is strictly greater than the unsigned threshold. The magnitude of the most negative value is 2^(SW-1).
- R5: After the triggering frame is written, exactly floor(L/2) further kept frames are written, where L is the event length in frames. In the cycle after the last word of the final frame is written, done is high for one cycle. With floor(L/2)=0, this is the cycle after the triggering frame is written.
- R6: With done, the start address becomes (address after the final word − L*WPF) mod 2^AW. It holds until the next done.
- R7: After a trigger, no further trigger occurs until an acknowledge arrives while the event is complete. An acknowledge at any other time has no effect.
- R8: A processor request is granted, combinationally, only when no frame is queued. A granted request drives the memory port with its own address, write flag and data. Read data from memory appears on the processor side, with a valid flag one cycle after a granted read.
- R9: The activity stream takes the largest channel magnitude over all channels of every valid input frame, whether kept or not. The interval is N valid frames (0 means 1). On the edge that accepts the interval's last frame, the stream outputs the maximum with a one-cycle strobe and starts a new interval from zero.
- R10: In reset, done, strobe, read-valid, start address and peak value are zero, the trigger is armed, and the decimation and interval counts restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample frame is present |
| smp_data | input | NCH*SW | Frame, channel c in bits [c*SW +: SW] |
| cfg_decim | input | DECW | Keep one frame in this many |
| cfg_len | input | LENW | Event length in frames |
| cfg_thresh | input | SW | Trigger magnitude threshold |
| cfg_chan | input | CHW | Channel watched by the trigger |
| cfg_ivl | input | IVLW | Activity interval in input frames |
| evt_ack | input | 1 | Re-arm after a completed event |
| evt_done | output | 1 | One-cycle event-complete pulse |
| evt_start | output | AW | Word address of the event's first word |
| peak_mag | output | SW | Largest magnitude of the last interval |
| peak_stb | output | 1 | New activity value |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_gnt | output | 1 | Processor request taken this cycle |
| cpu_rdata | output | 32 | Processor read data |
| cpu_rvalid | output | 1 | Processor read data valid |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The bench builds the block with two 16-bit channels, so each frame is exactly one memory word. A 6-bit address gives a 64-word buffer, so the write pointer wraps many times and start addresses that fall below zero are exercised. A 6-bit length allows events up to 63 frames, whose 31-frame tail crosses the wrap. Decimation and interval widths of 4 and 8 bits allow quick sweeps of D=0,1,3 and of one-frame and five-frame activity intervals. With one word per frame the queue never holds more than one entry, so the no-loss property is shown under back-to-back frames with a busy processor port.

// File: rtl/snapcap.sv
module snapcap #(
  parameter int NCH  = 2,
  parameter int SW   = 16,
  parameter int DW   = 32,
  parameter int AW   = 10,
  parameter int DECW = 8,
  parameter int LENW = 10,
  parameter int IVLW = 16,
  parameter int FD   = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic [DECW-1:0]   cfg_decim,
  input  logic [LENW-1:0]   cfg_len,
  input  logic [SW-1:0]     cfg_thresh,
  input  logic [CHW-1:0]    cfg_chan,
  input  logic [IVLW-1:0]   cfg_ivl,
  input  logic              evt_ack,
  output logic              evt_done,
  output logic [AW-1:0]     evt_start,
  output logic [SW-1:0]     peak_mag,
  output logic              peak_stb,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_gnt,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_rvalid,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int FW  = NCH * SW;
  localparam int WPF = FW / DW;
  localparam int WCW = (WPF > 1) ? $clog2(WPF) : 1;
  localparam int FPW = $clog2(FD);
  localparam logic [1:0] S_ARM = 2'd0, S_POST = 2'd1, S_HOLD = 2'd2;

  function automatic logic [SW-1:0] mag(input logic [SW-1:0] v);
    mag = v[SW-1] ? (~v + 1'b1) : v;
  endfunction

  logic [1:0] st;

  // channel magnitudes
  logic [SW-1:0] chmag [NCH];
  for (genvar c = 0; c < NCH; c++) begin : g_mag
    assign chmag[c] = mag(smp_data[c*SW +: SW]);
  end

  logic [SW-1:0] fmax;
  always_comb begin
    fmax = '0;
    for (int c = 0; c < NCH; c++)
      if (chmag[c] > fmax) fmax = chmag[c];
  end

  // decimation
  logic [DECW-1:0] dcnt;
  logic [DECW:0]   dnext;
  wire  [DECW-1:0] dlim = (cfg_decim == '0) ? DECW'(1) : cfg_decim;
  assign dnext = {1'b0, dcnt} + 1'b1;
  wire keep = smp_valid && (dcnt == '0);
  wire trig = keep && (st == S_ARM) && (chmag[cfg_chan] > cfg_thresh);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else if (smp_valid) dcnt <= (dnext >= {1'b0, dlim}) ? '0 : dnext[DECW-1:0];

  // frame queue
  logic [FW:0]    fmem [FD];
  logic [FPW-1:0] qrp, qwp;
  logic [FPW:0]   qcnt;
  logic [WCW-1:0] wsel;
  wire  [FW:0]    head = fmem[qrp];
  wire            qempty = (qcnt == '0);
  wire            qfull  = (qcnt == (FPW+1)'(FD));
  wire            last_word = (wsel == WCW'(WPF - 1));
  wire            pop = !qempty && last_word;

  always_ff @(posedge clk)
    if (keep) fmem[qwp] <= {trig, smp_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      qrp <= '0; qwp <= '0; qcnt <= '0; wsel <= '0;
    end else begin
      if (keep) qwp <= qwp + 1'b1;
      if (pop)  qrp <= qrp + 1'b1;
      case ({keep, pop})
        2'b10:   qcnt <= qcnt + 1'b1;
        2'b01:   qcnt <= qcnt - 1'b1;
        default: qcnt <= qcnt;
      endcase
      if (!qempty) wsel <= last_word ? '0 : wsel + 1'b1;
    end

  // memory port
  logic [AW-1:0] wptr;
  wire [DW-1:0] acq_word = head[int'(wsel)*DW +: DW];
  assign cpu_gnt   = cpu_req && qempty;
  assign mem_en    = !qempty || cpu_req;
  assign mem_we    = !qempty || (cpu_req && cpu_we);
  assign mem_addr  = qempty ? cpu_addr : wptr;
  assign mem_wdata = qempty ? cpu_wdata : acq_word;
  assign cpu_rdata = mem_rdata;

  // post-trigger tail
  logic [LENW-1:0] pcnt;
  logic            pact;
  wire  [LENW-1:0] half = cfg_len >> 1;
  wire             htrig = pop && head[FW];
  wire             fin = (htrig && half == '0) || (pop && !head[FW] && pact && pcnt == LENW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; pcnt <= '0; pact <= 1'b0; st <= S_ARM;
      evt_done <= 1'b0; evt_start <= '0; cpu_rvalid <= 1'b0;
    end else begin
      if (!qempty) wptr <= wptr + 1'b1;
      if (htrig) begin
        pact <= (half != '0);
        pcnt <= half;
      end else if (pop && pact) begin
        pcnt <= pcnt - 1'b1;
        if (pcnt == LENW'(1)) pact <= 1'b0;
      end
      evt_done <= fin;
      if (fin) evt_start <= wptr + 1'b1 - AW'(cfg_len * WPF);
      if (trig) st <= S_POST;
      else if (fin) st <= S_HOLD;
      else if (st == S_HOLD && evt_ack) st <= S_ARM;
      cpu_rvalid <= cpu_gnt && !cpu_we;
    end

  // activity peak
  logic [IVLW-1:0] icnt;
  logic [IVLW:0]   inext;
  logic [SW-1:0]   pacc;
  wire  [IVLW-1:0] ilim = (cfg_ivl == '0) ? IVLW'(1) : cfg_ivl;
  wire  [SW-1:0]   pnew = (fmax > pacc) ? fmax : pacc;
  assign inext = {1'b0, icnt} + 1'b1;
  wire iend = inext >= {1'b0, ilim};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      icnt <= '0; pacc <= '0; peak_mag <= '0; peak_stb <= 1'b0;
    end else begin
      peak_stb <= smp_valid && iend;
      if (smp_valid) begin
        if (iend) begin
          peak_mag <= pnew;
          pacc <= '0;
          icnt <= '0;
        end else begin
          pacc <= pnew;
          icnt <= inext[IVLW-1:0];
        end
      end
    end
endmodule

module snapcap_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          keep,
  input logic          qfull,
  input logic          pop,
  input logic          acq,
  input logic [AW-1:0] mem_addr,
  input logic          cpu_gnt,
  input logic          cpu_we,
  input logic          cpu_rvalid,
  input logic          evt_done,
  input logic [AW-1:0] evt_start
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    keep |-> (!qfull || pop));

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acq |=> (!acq || mem_addr == $past(mem_addr) + 1'b1));

  assert_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_gnt && !cpu_we));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);

  assert_start_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_done |-> $stable(evt_start));
endmodule

bind snapcap snapcap_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .keep(keep), .qfull(qfull), .pop(pop),
  .acq(!qempty), .mem_addr(mem_addr), .cpu_gnt(cpu_gnt), .cpu_we(cpu_we),
  .cpu_rvalid(cpu_rvalid), .evt_done(evt_done), .evt_start(evt_start)
);

// File: tb/test_snapcap.sv
module test_snapcap;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic [3:0]  cfg_decim = '0;
  logic [5:0]  cfg_len = '0;
  logic [15:0] cfg_thresh = '0;
  logic [0:0]  cfg_chan = '0;
  logic [7:0]  cfg_ivl = '0;
  logic        evt_ack = 1'b0;
  logic        evt_done, peak_stb;
  logic [5:0]  evt_start;
  logic [15:0] peak_mag;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_gnt, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_en, mem_we;
  logic [5:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  snapcap #(.NCH(2), .SW(16), .DW(32), .AW(6), .DECW(4), .LENW(6), .IVLW(8), .FD(4)) i_snapcap (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_decim(cfg_decim), .cfg_len(cfg_len), .cfg_thresh(cfg_thresh),
    .cfg_chan(cfg_chan), .cfg_ivl(cfg_ivl), .evt_ack(evt_ack),
    .evt_done(evt_done), .evt_start(evt_start), .peak_mag(peak_mag), .peak_stb(peak_stb),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  logic [31:0] ram [64];
  always @(posedge clk)
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    else if (mem_en) mem_rdata <= ram[mem_addr];

  int nchk = 0, nerr = 0, cyc = 0;
  bit cpu_on = 0;

  // reference model state
  logic [32:0] q [$];
  logic [31:0] mref [64];
  int m_wp = 0, m_dc = 0, m_st = 0, m_pc = 0, m_ic = 0, m_acc = 0;
  int m_start = 0, m_peak = 0, m_raddr = 0;
  bit m_pact = 0, m_done = 0, m_stb = 0, m_rv = 0;

  function automatic int magn(logic [15:0] v);
    return v[15] ? 65536 - int'(v) : int'(v);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] d, input bit ack);
    bit acq, keep, t, nd;
    logic [32:0] f;
    int dl, il, fm, a, len;
    @(negedge clk);
    smp_valid = v; smp_data = d; evt_ack = ack;
    if (cpu_on) begin
      cpu_req = (cyc % 3) != 0;
      cpu_we = (cyc % 5) == 0;
      cpu_addr = 6'((cyc * 7) % 64);
      cpu_wdata = 32'(cyc) * 32'h01000193;
    end else cpu_req = 1'b0;
    cyc++;
    #1;
    acq = q.size() > 0;
    chk("R8 cpu_gnt", cpu_gnt, cpu_req && !acq);
    chk("R3 mem_en", mem_en, acq || cpu_req);
    chk("R3 mem_we", mem_we, acq || (cpu_req && cpu_we));
    if (acq) begin
      chk("R1 mem_addr", mem_addr, 64'(m_wp));
      chk("R1/R2 stored frame", mem_wdata, q[0][31:0]);
    end else if (cpu_req) begin
      chk("R8 cpu mem_addr", mem_addr, cpu_addr);
      if (cpu_we) chk("R8 cpu mem_wdata", mem_wdata, cpu_wdata);
    end
    chk("R4/R5/R7 evt_done", evt_done, m_done);
    chk("R6 evt_start", evt_start, 64'(m_start));
    chk("R9 peak_stb", peak_stb, m_stb);
    chk("R9 peak_mag", peak_mag, 64'(m_peak));
    chk("R8 cpu_rvalid", cpu_rvalid, m_rv);
    if (m_rv) chk("R8 cpu_rdata", cpu_rdata, mref[m_raddr]);
    // advance the model across the coming edge
    len = int'(cfg_len);
    nd = 0;
    if (acq) begin
      f = q.pop_front();
      mref[m_wp] = f[31:0];
      if (f[32]) begin
        if (len / 2 == 0) nd = 1;
        else begin m_pact = 1; m_pc = len / 2; end
      end else if (m_pact) begin
        if (m_pc == 1) begin nd = 1; m_pact = 0; end
        m_pc--;
      end
      if (nd) m_start = (m_wp + 1 - len) & 63;
      m_wp = (m_wp + 1) & 63;
    end else if (cpu_req && cpu_we) mref[cpu_addr] = cpu_wdata;
    m_rv = cpu_req && !acq && !cpu_we;
    m_raddr = int'(cpu_addr);
    m_stb = 0;
    t = 0;
    if (v) begin
      keep = (m_dc == 0);
      dl = (cfg_decim == 0) ? 1 : int'(cfg_decim);
      m_dc = (m_dc + 1 >= dl) ? 0 : m_dc + 1;
      if (keep) begin
        t = (m_st == 0) && (magn(cfg_chan[0] ? d[31:16] : d[15:0]) > int'(cfg_thresh));
        q.push_back({t, d});
      end
      fm = magn(d[15:0]) > magn(d[31:16]) ? magn(d[15:0]) : magn(d[31:16]);
      a = fm > m_acc ? fm : m_acc;
      il = (cfg_ivl == 0) ? 1 : int'(cfg_ivl);
      if (m_ic + 1 >= il) begin m_peak = a; m_stb = 1; m_acc = 0; m_ic = 0; end
      else begin m_acc = a; m_ic++; end
    end
    if (t) m_st = 1;
    else if (nd) m_st = 2;
    else if (m_st == 2 && ack) m_st = 0;
    m_done = nd;
  endtask

  function automatic logic [31:0] bg(int i);
    return {16'(((i * 53) % 180) - 90), 16'(((i * 37) % 200) - 100)};
  endfunction

  task automatic frames(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1, bg(cyc), 0);
      for (int g = 0; g < gap; g++) step(0, '0, 0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    nerr++;
    $display("FAIL watchdog: run still going at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin ram[i] = '0; mref[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset evt_done", evt_done, 0);
    chk("R10 reset evt_start", evt_start, 0);
    chk("R10 reset peak_mag", peak_mag, 0);
    chk("R10 reset peak_stb", peak_stb, 0);
    chk("R10 reset cpu_rvalid", cpu_rvalid, 0);
    chk("R10 reset mem_en", mem_en, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 keep all, R4 trigger on channel 0, R5 tail of four frames
    cfg_decim = 4'd1; cfg_len = 6'd8; cfg_thresh = 16'd1000; cfg_chan = 1'b0; cfg_ivl = 8'd5;
    cpu_on = 1;
    frames(20, 2);
    step(1, {16'd3, 16'd1500}, 0);
    step(0, '0, 1);                    // R7 ack during tail: no effect
    frames(8, 2);
    step(1, {16'd0, 16'd2000}, 0);     // R7 no trigger while holding
    frames(3, 1);
    step(0, '0, 1);                    // R7 re-arm

    // R4 equal to threshold, and large value on the unwatched channel
    step(1, {16'd0, 16'd1000}, 0);
    step(1, {16'd5000, 16'd0}, 0);
    frames(6, 1);

    // R2 decimation by 3, R4 most negative value on channel 1, R5 odd length
    cfg_chan = 1'b1; cfg_decim = 4'd3; cfg_len = 6'd5; cfg_thresh = 16'd2000;
    for (int i = 0; i < 4; i++) step(1, {16'h8000, 16'd7}, 0);
    frames(12, 1);
    step(0, '0, 1);

    // R5 length one: done right after the trigger frame
    cfg_decim = 4'd0; cfg_len = 6'd1; cfg_thresh = 16'd50; cfg_ivl = 8'd0;
    frames(6, 0);
    step(0, '0, 1);
    frames(4, 0);
    step(0, '0, 1);

    // R1/R6 long event across the buffer wrap, back-to-back frames
    cfg_len = 6'd63; cfg_thresh = 16'd20000; cfg_ivl = 8'd7;
    frames(70, 0);
    step(1, {16'd30000, 16'd1}, 0);
    frames(40, 0);
    step(0, '0, 1);
    cfg_decim = 4'd2;
    frames(30, 1);
    cpu_on = 0;
    idle(5);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule